// File: doc/BRIEF.md
# Autoincrement Shared-RAM Host Port

This block sits between a host bus and the shared RAM of an I/O coprocessor. The host sees four byte-wide registers, chosen by a two-bit select. Two of them hold the low and high bytes of a RAM pointer. One is a data window onto the byte at that pointer. The last is a control/status byte that runs or halts the coprocessor, selects bypass, rings the coprocessor's interrupt and reports two host interrupt causes.

With autoincrement enabled, every access through the data window advances the pointer by one. One pointer load can then stream a whole code image into the RAM, read it back or compare it. The RAM itself lives outside the block. The block drives its address, write strobe and write data, and returns the RAM's combinational read data to the host. A liveness check is an ordinary use of the port: the host points at the agreed liveness byte, expects 0xFF from a running coprocessor, and writes 0 back.

Top module: `shared_ram_port`

## Requirements
- R1: After reset the pointer is 0x0000, the control byte reads 0x00, and cop_run, cop_bypass, cop_irq and host_irq are low.
- R2: Select code 0 writes and reads back pointer bits 7:0, and select code 1 writes and reads back pointer bits 15:8. A write to one byte leaves the other byte unchanged.
- R3: Select code 2 reads the RAM byte at the current pointer, and a write through it drives mem_wr with mem_addr equal to the pointer and mem_wdata equal to the written byte.
- R4: While control bit 1 (autoincrement) is set, each data read or data write moves the pointer up by one in the following cycle. While the bit is clear, data accesses leave the pointer unchanged.
- R5: An autoincrement from 0xFFFF yields 0x0000.
- R6: Select code 3 writes control bit 2 (run) to cop_run and bit 0 (bypass) to cop_bypass, and bits 2:0 read back as written.
- R7: Control bit 3 drives cop_irq. It stays set until cop_irq_ack clears it, and a host write in the same cycle as the acknowledge decides the bit.
- R8: A cop_int0_set pulse sets control bit 4 and a cop_int1_set pulse sets control bit 5. host_irq is high whenever either bit is set.
- R9: Bits 4 and 5 clear only when the host writes 1 to them, and writing 0 leaves them as they are. A set pulse in the same cycle as a clear leaves the bit set.
- R10: Control bits 7:6 always read 0, and writes to them have no effect.
- R11: Accesses to the pointer or control registers never produce mem_wr and never step the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_sel | input | 2 | Register select: 0 ptr low, 1 ptr high, 2 data, 3 control |
| hst_wr | input | 1 | Host write strobe, one cycle per access |
| hst_rd | input | 1 | Host read strobe, one cycle per access |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Byte of the selected register |
| host_irq | output | 1 | Host interrupt, either cause pending |
| mem_addr | output | ADDR_W | Shared-RAM address (current pointer) |
| mem_wr | output | 1 | Shared-RAM write strobe |
| mem_wdata | output | 8 | Shared-RAM write byte |
| mem_rdata | input | 8 | Shared-RAM read byte for mem_addr |
| cop_run | output | 1 | Coprocessor run enable |
| cop_bypass | output | 1 | Bypass select |
| cop_irq | output | 1 | Interrupt request to the coprocessor |
| cop_irq_ack | input | 1 | Coprocessor clears its interrupt request |
| cop_int0_set | input | 1 | Coprocessor raises host cause 0 |
| cop_int1_set | input | 1 | Coprocessor raises host cause 1 |

## Verification
The checks assume that a host access asserts either the read strobe or the write strobe, never both in one cycle. Under that assumption one access maps to at most one pointer step. The random stimulus picks a single operation per cycle, so the two strobes stay exclusive. The coprocessor pulses and the acknowledge are random and independent of the host, so they often land in the same cycle as a control write that sets or clears the same bit. Directed cases cover pointer wrap, streaming upload and read-back, and the liveness handshake.

// File: rtl/sp_pkg.sv
package sp_pkg;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {
      SP_REG_PTR_LO = 2'd0,
      SP_REG_PTR_HI = 2'd1,
      SP_REG_DATA   = 2'd2,
      SP_REG_CTRL   = 2'd3
   } sp_reg_e;

   // Bit positions inside the control byte.
   localparam int unsigned CB_BYPASS  = 0;
   localparam int unsigned CB_AUTOINC = 1;
   localparam int unsigned CB_RUN     = 2;
   localparam int unsigned CB_IRQ     = 3;
   localparam int unsigned CB_INT0    = 4;
   localparam int unsigned CB_INT1    = 5;
   localparam int unsigned CB_USED    = 6;

   // Packed order matches the bit positions above.
   typedef struct packed {
      logic int1;
      logic int0;
      logic irq;
      logic run;
      logic autoinc;
      logic bypass;
   } sp_ctrl_t;
endpackage

// File: rtl/sp_addr_ptr.sv
module sp_addr_ptr #(
   parameter int unsigned ADDR_W     = 16,
   parameter bit          AUTOINC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_lo,
   input  logic              ld_hi,
   input  logic [7:0]        wbyte,
   input  logic              step,
   output logic [ADDR_W-1:0] addr
);
   localparam int unsigned HI_W = ADDR_W - 8;
   localparam logic [ADDR_W-1:0] ADDR_MAX = {ADDR_W{1'b1}};

   logic step_eff;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_width
         $error("sp_addr_ptr: ADDR_W must lie in 9..16");
      end
      if (AUTOINC_EN) begin : g_inc
         assign step_eff = step;
      end else begin : g_noinc
         assign step_eff = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (ld_lo) begin
         addr[7:0] <= wbyte;
      end else if (ld_hi) begin
         addr[ADDR_W-1:8] <= wbyte[HI_W-1:0];
      end else if (step_eff) begin
         addr <= addr + 1'b1;
      end
   end

   assert_lo_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_lo |=> addr[7:0] == $past(wbyte));

   assert_hi_keeps_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_hi && !ld_lo) |=> addr[7:0] == $past(addr[7:0]));

   assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_lo || ld_hi || step) |=> $stable(addr));

   generate
      if (AUTOINC_EN) begin : g_inc_chk
         assert_step_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (step && !ld_lo && !ld_hi) |=> addr == $past(addr) + 1'b1);

         assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (step && !ld_lo && !ld_hi && addr == ADDR_MAX) |=> addr == '0);
      end
   endgenerate
endmodule

// File: rtl/sp_ctrl_reg.sv
module sp_ctrl_reg
   import sp_pkg::*;
#(
   parameter bit AUTOINC_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_ctrl,
   input  logic [7:0] wbyte,
   input  logic       int0_set,
   input  logic       int1_set,
   input  logic       irq_ack,
   output sp_ctrl_t   q
);
   sp_ctrl_t d;
   logic     inc_bit;

   generate
      if (AUTOINC_EN) begin : g_inc_bit
         assign inc_bit = wbyte[CB_AUTOINC];
      end else begin : g_no_inc_bit
         assign inc_bit = 1'b0;
      end
   endgenerate

   always_comb begin
      d = q;
      if (wr_ctrl) begin
         d.bypass  = wbyte[CB_BYPASS];
         d.autoinc = inc_bit;
         d.run     = wbyte[CB_RUN];
         d.irq     = wbyte[CB_IRQ];
      end else if (irq_ack) begin
         d.irq = 1'b0;
      end
      d.int0 = int0_set | (q.int0 & ~(wr_ctrl & wbyte[CB_INT0]));
      d.int1 = int1_set | (q.int1 & ~(wr_ctrl & wbyte[CB_INT1]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

   assert_run_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> q.run == $past(wbyte[CB_RUN]));

   assert_irq_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !wr_ctrl) |=> !q.irq);

   assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (q.irq && !irq_ack && !wr_ctrl) |=> q.irq);

   assert_int0_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      int0_set |=> q.int0);

   assert_int1_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      int1_set |=> q.int1);

   assert_int0_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wbyte[CB_INT0] && !int0_set) |=> !q.int0);

   assert_int0_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (q.int0 && !(wr_ctrl && wbyte[CB_INT0])) |=> q.int0);
endmodule

// File: rtl/sp_read_mux.sv
module sp_read_mux
   import sp_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
) (
   input  logic [1:0]        sel,
   input  logic [ADDR_W-1:0] addr,
   input  sp_ctrl_t          ctrl,
   input  logic [7:0]        mem_rdata,
   output logic [7:0]        rdata
);
   localparam int unsigned HI_W = ADDR_W - 8;

   logic [7:0] hi_byte;

   generate
      if (HI_W < 8) begin : g_hi_pad
         assign hi_byte = {{(8 - HI_W){1'b0}}, addr[ADDR_W-1:8]};
      end else begin : g_hi_full
         assign hi_byte = addr[ADDR_W-1:8];
      end
   endgenerate

   always_comb begin
      unique case (sel)
         SP_REG_PTR_LO: rdata = addr[7:0];
         SP_REG_PTR_HI: rdata = hi_byte;
         SP_REG_DATA:   rdata = mem_rdata;
         default:       rdata = {{(8 - CB_USED){1'b0}}, ctrl};
      endcase
   end
endmodule

// File: rtl/shared_ram_port.sv
module shared_ram_port
   import sp_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter bit          AUTOINC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        hst_sel,
   input  logic              hst_wr,
   input  logic              hst_rd,
   input  logic [7:0]        hst_wdata,
   output logic [7:0]        hst_rdata,
   output logic              host_irq,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_wr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   output logic              cop_run,
   output logic              cop_bypass,
   output logic              cop_irq,
   input  logic              cop_irq_ack,
   input  logic              cop_int0_set,
   input  logic              cop_int1_set
);
   sp_ctrl_t          ctrl_q;
   logic [ADDR_W-1:0] ptr;
   logic              sel_data, data_acc, step;

   assign sel_data = (hst_sel == SP_REG_DATA);
   assign data_acc = sel_data && (hst_wr || hst_rd);
   assign step     = data_acc && ctrl_q.autoinc;

   sp_addr_ptr #(.ADDR_W(ADDR_W), .AUTOINC_EN(AUTOINC_EN)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .ld_lo (hst_wr && hst_sel == SP_REG_PTR_LO),
      .ld_hi (hst_wr && hst_sel == SP_REG_PTR_HI),
      .wbyte (hst_wdata),
      .step  (step),
      .addr  (ptr)
   );

   sp_ctrl_reg #(.AUTOINC_EN(AUTOINC_EN)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (hst_wr && hst_sel == SP_REG_CTRL),
      .wbyte    (hst_wdata),
      .int0_set (cop_int0_set),
      .int1_set (cop_int1_set),
      .irq_ack  (cop_irq_ack),
      .q        (ctrl_q)
   );

   sp_read_mux #(.ADDR_W(ADDR_W)) u_rmux (
      .sel       (hst_sel),
      .addr      (ptr),
      .ctrl      (ctrl_q),
      .mem_rdata (mem_rdata),
      .rdata     (hst_rdata)
   );

   assign mem_addr   = ptr;
   assign mem_wr     = hst_wr && sel_data;
   assign mem_wdata  = hst_wdata;
   assign cop_run    = ctrl_q.run;
   assign cop_bypass = ctrl_q.bypass;
   assign cop_irq    = ctrl_q.irq;
   assign host_irq   = ctrl_q.int0 | ctrl_q.int1;

   // Input assumption: one strobe per access (covers R4 step counting).
   always_comb begin
      if (rst_n) begin
         assert_strobe_excl_R4: assert (!(hst_rd && hst_wr));
      end
   end

   assert_host_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cop_int0_set || cop_int1_set) |=> host_irq);

   assert_irq_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_wr && hst_sel == SP_REG_CTRL) |=> cop_irq == $past(hst_wdata[CB_IRQ]));

   assert_no_ptr_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_wr && !sel_data) |-> !mem_wr);
endmodule

// File: tb/shared_ram_port_tb.sv
module shared_ram_port_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] hst_sel = '0;
   logic       hst_wr = 1'b0, hst_rd = 1'b0;
   logic [7:0] hst_wdata = '0;
   logic [7:0] hst_rdata;
   logic       host_irq;
   logic [15:0] mem_addr;
   logic       mem_wr;
   logic [7:0] mem_wdata;
   logic [7:0] mem_rdata = '0;
   logic       cop_run, cop_bypass, cop_irq;
   logic       cop_irq_ack = 1'b0, cop_int0_set = 1'b0, cop_int1_set = 1'b0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   shared_ram_port dut_i (
      .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
      .hst_rd(hst_rd), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
      .host_irq(host_irq), .mem_addr(mem_addr), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cop_run(cop_run),
      .cop_bypass(cop_bypass), .cop_irq(cop_irq), .cop_irq_ack(cop_irq_ack),
      .cop_int0_set(cop_int0_set), .cop_int1_set(cop_int1_set)
   );

   // Stand-in shared RAM: sparse storage over a computed background.
   logic [7:0] ram [int];
   int ram_gen = 0;

   function automatic logic [7:0] ram_get(input logic [15:0] a);
      if (ram.exists(int'(a))) return ram[int'(a)];
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction

   always @(posedge clk) begin
      if (mem_wr) begin
         ram[int'(mem_addr)] = mem_wdata;
         ram_gen = ram_gen + 1;
      end
   end

   always @(mem_addr or ram_gen) mem_rdata = ram_get(mem_addr);

   // Bench model of the registers.
   logic [15:0] m_addr = '0;
   logic [5:0]  m_ctrl = '0;   // {int1,int0,irq,run,autoinc,bypass}
   logic [7:0]  last_rd;

   task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(input logic [1:0] sel);
      case (sel)
         2'd0: return m_addr[7:0];
         2'd1: return m_addr[15:8];
         2'd2: return ram_get(m_addr);
         default: return {2'b00, m_ctrl};
      endcase
   endfunction

   task automatic do_cycle(input logic [1:0] sel, input logic wr, input logic rd,
                           input logic [7:0] wd, input logic i0, input logic i1,
                           input logic ack, input string req);
      logic [15:0] na;
      logic [5:0]  nc;
      logic        wctl;
      @(negedge clk);
      hst_sel = sel; hst_wr = wr; hst_rd = rd; hst_wdata = wd;
      cop_int0_set = i0; cop_int1_set = i1; cop_irq_ack = ack;
      #1;
      last_rd = hst_rdata;
      if (rd) check8(hst_rdata, exp_read(sel), {req, " read R3"});
      check8({7'd0, mem_wr}, {7'd0, wr && sel == 2'd2}, "R11 mem_wr");
      if (wr && sel == 2'd2) begin
         check8(mem_addr[7:0], m_addr[7:0], "R3 mem_addr lo");
         check8(mem_addr[15:8], m_addr[15:8], "R3 mem_addr hi");
         check8(mem_wdata, wd, "R3 mem_wdata");
      end
      na = m_addr;
      if (wr && sel == 2'd0) na[7:0] = wd;
      else if (wr && sel == 2'd1) na[15:8] = wd;
      else if (sel == 2'd2 && (wr || rd) && m_ctrl[1]) na = m_addr + 16'd1;
      wctl = wr && sel == 2'd3;
      nc = m_ctrl;
      if (wctl) nc[3:0] = wd[3:0];
      else if (ack) nc[3] = 1'b0;
      nc[4] = i0 | (m_ctrl[4] & ~(wctl & wd[4]));
      nc[5] = i1 | (m_ctrl[5] & ~(wctl & wd[5]));
      @(posedge clk);
      m_addr = na; m_ctrl = nc;
      #1;
      hst_wr = 1'b0; hst_rd = 1'b0;
      cop_int0_set = 1'b0; cop_int1_set = 1'b0; cop_irq_ack = 1'b0;
      check8({7'd0, cop_run}, {7'd0, m_ctrl[2]}, "R6 cop_run");
      check8({7'd0, cop_bypass}, {7'd0, m_ctrl[0]}, "R6 cop_bypass");
      check8({7'd0, cop_irq}, {7'd0, m_ctrl[3]}, "R7 cop_irq");
      check8({7'd0, host_irq}, {7'd0, m_ctrl[4] | m_ctrl[5]}, "R8 host_irq");
   endtask

   task automatic hwr(input logic [1:0] sel, input logic [7:0] wd, input string req);
      do_cycle(sel, 1'b1, 1'b0, wd, 1'b0, 1'b0, 1'b0, req);
   endtask

   task automatic hrd(input logic [1:0] sel, input string req);
      do_cycle(sel, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, req);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check8({4'd0, cop_run, cop_bypass, cop_irq, host_irq}, 8'h00, "R1 outputs");
      hst_sel = 2'd3; #1; check8(hst_rdata, 8'h00, "R1 ctrl");
      hst_sel = 2'd0; #1; check8(hst_rdata, 8'h00, "R1 ptr lo");
      hst_sel = 2'd1; #1; check8(hst_rdata, 8'h00, "R1 ptr hi");
      @(negedge clk); rst_n = 1'b1;

      // R2 pointer bytes and readback
      hwr(2'd0, 8'h34, "R2");
      hwr(2'd1, 8'h12, "R2");
      hrd(2'd0, "R2"); check8(last_rd, 8'h34, "R2 lo readback");
      hrd(2'd1, "R2"); check8(last_rd, 8'h12, "R2 hi readback");

      // R4 off: data accesses leave the pointer still
      hwr(2'd2, 8'h5C, "R4");
      hwr(2'd2, 8'h6D, "R4");
      hrd(2'd0, "R4"); check8(last_rd, 8'h34, "R4 no step");
      hrd(2'd2, "R3"); check8(last_rd, 8'h6D, "R3 data readback");

      // R4 streaming upload and read-back with autoincrement
      hwr(2'd3, 8'h06, "R6");
      hwr(2'd0, 8'h00, "R4"); hwr(2'd1, 8'h20, "R4");
      for (int k = 0; k < 8; k++) hwr(2'd2, 8'(8'h10 + k * 3), "R4");
      hrd(2'd0, "R4"); check8(last_rd, 8'h08, "R4 stepped 8");
      hwr(2'd0, 8'h00, "R4");
      for (int k = 0; k < 8; k++) begin
         hrd(2'd2, "R4"); check8(last_rd, 8'(8'h10 + k * 3), "R4 stream readback");
      end

      // R5 wrap
      hwr(2'd0, 8'hFF, "R5"); hwr(2'd1, 8'hFF, "R5");
      hrd(2'd2, "R5");
      hrd(2'd0, "R5"); check8(last_rd, 8'h00, "R5 wrap lo");
      hrd(2'd1, "R5"); check8(last_rd, 8'h00, "R5 wrap hi");

      // Liveness byte handshake through the data window
      ram[16'h00F0] = 8'hFF; ram_gen++;
      hwr(2'd3, 8'h04, "R6");
      hwr(2'd0, 8'hF0, "R3"); hwr(2'd1, 8'h00, "R3");
      hrd(2'd2, "R3"); check8(last_rd, 8'hFF, "R3 liveness");
      hwr(2'd2, 8'h00, "R3");
      hrd(2'd2, "R3"); check8(last_rd, 8'h00, "R3 liveness cleared");

      // R6/R10 control readback, upper bits ignored
      hwr(2'd3, 8'hC5, "R10");
      hrd(2'd3, "R10"); check8(last_rd, 8'h05, "R10 upper bits");

      // R7 irq: set, hold, ack; write wins over ack
      hwr(2'd3, 8'h0C, "R7");
      do_cycle(2'd0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R7");
      check8({7'd0, cop_irq}, 8'h01, "R7 held");
      do_cycle(2'd0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R7");
      check8({7'd0, cop_irq}, 8'h00, "R7 acked");
      do_cycle(2'd3, 1'b1, 1'b0, 8'h0C, 1'b0, 1'b0, 1'b1, "R7");
      check8({7'd0, cop_irq}, 8'h01, "R7 write wins");

      // R8/R9 interrupt causes
      do_cycle(2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R8");
      check8({7'd0, host_irq}, 8'h01, "R8 int0 raises");
      hwr(2'd3, 8'h24, "R9");
      hrd(2'd3, "R9"); check8(last_rd, 8'h14, "R9 write0 keeps int0");
      do_cycle(2'd3, 1'b1, 1'b0, 8'h14, 1'b1, 1'b1, 1'b0, "R9");
      hrd(2'd3, "R9"); check8(last_rd, 8'h34, "R9 set beats clear");
      hwr(2'd3, 8'h34, "R9");
      check8({7'd0, host_irq}, 8'h00, "R9 both cleared");

      // Random mix
      for (int n = 0; n < 1500; n++) begin
         int op;
         logic [7:0] wd;
         op = $urandom_range(0, 7);
         wd = 8'($urandom);
         case (op)
            0, 1: do_cycle(2'($urandom_range(0, 3)), 1'b0, 1'b1, 8'h00,
                           1'($urandom_range(0, 9) == 0), 1'($urandom_range(0, 9) == 0),
                           1'($urandom_range(0, 5) == 0), "rand");
            2, 3: do_cycle(2'd2, 1'b1, 1'b0, wd, 1'($urandom_range(0, 9) == 0), 1'b0,
                           1'($urandom_range(0, 5) == 0), "rand");
            4:    do_cycle(2'($urandom_range(0, 1)), 1'b1, 1'b0, wd, 1'b0,
                           1'($urandom_range(0, 9) == 0), 1'b0, "rand");
            5:    do_cycle(2'd3, 1'b1, 1'b0, wd, 1'($urandom_range(0, 3) == 0),
                           1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0), "rand");
            default: do_cycle(2'd2, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, "rand");
         endcase
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule